// File: doc/BRIEF.md
# Register Bank with Status Flags and Program Counter

This block is the architectural register store of a small 16-bit processor. Each register is addressed by a 3-bit code. Two operand read ports serve the arithmetic sources. A third read port returns the destination register, which stores and high-byte inserts need. A single synchronous write port updates the addressed register.

The block has a separate flag port. It loads the four arithmetic status bits from the ALU whenever the flag enable is high.

The block also holds the program counter, which is visible as an ordinary register code. The current counter value is driven out for instruction fetch, and the zero status bit is driven out for conditional-execution logic. On every clock edge the counter advances by one, unless that edge writes to the counter. In that case the written value is loaded instead.

Top module: `regbank_flagpc`

## Requirements
- R1: While `rst_n` is low and after reset, every code reads 0, `pc_out` is 0 and `z_flag` is 0.
- R2: Code 0 reads 0 on every read port, even after a write to code 0.
- R3: Codes 1 to 4 are general registers. A write with `wr_en` high stores `wr_data` at the clock edge, and the value is then visible on all three read ports.
- R4: Code 5 reads as the status word: Z at bit 0, N at bit 1, C at bit 2, V at bit 3, and bits 15..4 are 0. `flag_in` carries the bits in the same positions, {V,C,N,Z}. With `flag_en` high, the status word loads `flag_in` at the clock edge.
- R5: With `flag_en` low, the status bits keep their value.
- R6: Writes to code 5 and code 6 leave every register unchanged, and code 6 always reads 0.
- R7: When an edge does not write code 7, the counter becomes its previous value plus one, modulo 2^16.
- R8: A write to code 7 loads `wr_data` into the counter in place of the increment. Code 7 reads return the same value as `pc_out`.
- R9: `z_flag` always equals bit 0 of the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_a | input | 3 | First operand register code |
| data_a | output | 16 | First operand value |
| sel_b | input | 3 | Second operand register code |
| data_b | output | 16 | Second operand value |
| sel_d | input | 3 | Destination register code for read |
| data_d | output | 16 | Destination register value |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 3 | Write register code |
| wr_data | input | 16 | Write value |
| flag_en | input | 1 | Status load enable |
| flag_in | input | 4 | Status bits from the ALU, {V,C,N,Z} |
| pc_out | output | 16 | Current program counter |
| z_flag | output | 1 | Current zero status bit |

## Verification
The bench builds the block with its defaults: a 16-bit word and four general registers. At this size every one of the eight codes can be written and then read back on all three ports. All sixteen status patterns can be loaded and then held. The full counter range is in reach, so the wrap from 0xFFFF to 0 is forced by writing the counter near its top.

// File: rtl/regbank_pkg.sv
// Shared register codes and status bit layout for the register bank.
// Assumes 3-bit register codes; the code map is fixed by the instruction set.
package regbank_pkg;
    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] CODE_ZERO  = 3'd0;
    localparam logic [CODE_W-1:0] CODE_FLAGS = 3'd5;
    localparam logic [CODE_W-1:0] CODE_HOLE  = 3'd6;
    localparam logic [CODE_W-1:0] CODE_PC    = 3'd7;
    localparam int FLAG_W = 4;

    // Packed so that z lands on bit 0 and v on bit 3.
    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } flags_t;
endpackage

// File: rtl/gpr_array.sv
// General-purpose registers occupying codes 1..NUM_GPR.
// Assumes NUM_GPR codes fit below the status code; writes to other codes are ignored.
module gpr_array
    import regbank_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_GPR = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [CODE_W-1:0]              wr_sel,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q
);
    for (genvar i = 0; i < NUM_GPR; i++) begin : g_reg
        localparam logic [CODE_W-1:0] MY_CODE = CODE_W'(i + 1);
        // Load this register when the write port addresses its code.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gpr_q[i] <= '0;
            end else if (wr_en && wr_sel == MY_CODE) begin
                gpr_q[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/flag_reg.sv
// Status register loaded only from the dedicated ALU port under flag_en.
// Assumes the general write port never touches it.
module flag_reg
    import regbank_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   flag_en,
    input  flags_t flag_d,
    output flags_t flag_q
);
    // Capture the ALU status when enabled, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (flag_en) begin
            flag_q <= flag_d;
        end
    end
endmodule

// File: rtl/pc_reg.sv
// Program counter: loads a write to its code, otherwise advances by one.
// Assumes wrap-around at 2^PC_W.
module pc_reg
    import regbank_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_sel,
    input  logic [PC_W-1:0]   wr_data,
    output logic [PC_W-1:0]   pc_q
);
    logic load_pc;
    logic [PC_W-1:0] pc_next;

    // Pick the explicit write or the sequential successor.
    always_comb begin
        load_pc = wr_en && (wr_sel == CODE_PC);
        pc_next = load_pc ? wr_data : pc_q + PC_W'(1);
    end

    // Advance the counter every cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end
endmodule

// File: rtl/read_port.sv
// Combinational selector from register code to value for one read port.
// Assumes reserved status bits and unused codes read as zero.
module read_port
    import regbank_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_GPR = 4
) (
    input  logic [CODE_W-1:0]              sel,
    input  logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q,
    input  flags_t                         flag_q,
    input  logic [DATA_W-1:0]              pc_q,
    output logic [DATA_W-1:0]              data
);
    localparam int PAD_W = DATA_W - FLAG_W;

    // Decode the code into its source; anything unmapped gives zero.
    always_comb begin
        data = '0;
        for (int i = 0; i < NUM_GPR; i++) begin
            if (sel == CODE_W'(i + 1)) begin
                data = gpr_q[i];
            end
        end
        if (sel == CODE_FLAGS) begin
            data = {{PAD_W{1'b0}}, flag_q};
        end
        if (sel == CODE_PC) begin
            data = pc_q;
        end
    end
endmodule

// File: rtl/regbank_flagpc.sv
// Register bank top: zero code, general registers, status word and program
// counter behind three read ports and one write port.
// Assumes the sequencer drives one write per cycle; the pc advances each cycle.
module regbank_flagpc
    import regbank_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_GPR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel_a,
    output logic [DATA_W-1:0] data_a,
    input  logic [2:0]        sel_b,
    output logic [DATA_W-1:0] data_b,
    input  logic [2:0]        sel_d,
    output logic [DATA_W-1:0] data_d,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_en,
    input  logic [3:0]        flag_in,
    output logic [DATA_W-1:0] pc_out,
    output logic              z_flag
);
    localparam int NUM_RD = 3;

    logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q;
    flags_t                         flag_q;
    logic [DATA_W-1:0]              pc_q;
    logic [NUM_RD-1:0][CODE_W-1:0]  rd_sel;
    logic [NUM_RD-1:0][DATA_W-1:0]  rd_data;

    // Gather the read selects into one vector.
    always_comb begin
        rd_sel[0] = sel_a;
        rd_sel[1] = sel_b;
        rd_sel[2] = sel_d;
    end

    gpr_array #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .gpr_q   (gpr_q)
    );

    flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_en (flag_en),
        .flag_d  (flags_t'(flag_in)),
        .flag_q  (flag_q)
    );

    pc_reg #(.PC_W(DATA_W)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pc_q    (pc_q)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        read_port #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_rd (
            .sel    (rd_sel[p]),
            .gpr_q  (gpr_q),
            .flag_q (flag_q),
            .pc_q   (pc_q),
            .data   (rd_data[p])
        );
    end

    // Drive the outward-facing values.
    always_comb begin
        data_a = rd_data[0];
        data_b = rd_data[1];
        data_d = rd_data[2];
        pc_out = pc_q;
        z_flag = flag_q.z;
    end
endmodule

// File: rtl/regbank_flagpc_chk.sv
// Port-level checker for the register bank, bound to every instance.
// Assumes DATA_W of at least 5 so reserved status bits exist.
module regbank_flagpc_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        sel_a,
    input logic [DATA_W-1:0] data_a,
    input logic [2:0]        sel_b,
    input logic [DATA_W-1:0] data_b,
    input logic [2:0]        sel_d,
    input logic [DATA_W-1:0] data_d,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              flag_en,
    input logic [3:0]        flag_in,
    input logic [DATA_W-1:0] pc_out,
    input logic              z_flag
);
    logic armed;

    // Mark that one full cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !($past(wr_en) && $past(wr_sel) == 3'd7) |-> pc_out == $past(pc_out) + DATA_W'(1));
    p_pc_load_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(wr_en) && $past(wr_sel) == 3'd7) |-> pc_out == $past(wr_data));
    p_pc_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_d == 3'd7 |-> data_d == pc_out);
    p_flag_load_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(flag_en) |-> z_flag == $past(flag_in[0]));
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(flag_en) |-> $stable(z_flag));
    p_flag_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_b == 3'd5 |-> data_b[DATA_W-1:4] == '0);
    p_zero_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_a == 3'd0 |-> data_a == '0);
    p_hole_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_a == 3'd6 |-> data_a == '0);
    p_zout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_d == 3'd5 |-> data_d[0] == z_flag);
endmodule

bind regbank_flagpc regbank_flagpc_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_regbank_flagpc.sv
`timescale 1ns/100ps
module test_regbank_flagpc;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [2:0]   sel_a, sel_b, sel_d, wr_sel;
    logic [W-1:0] data_a, data_b, data_d, wr_data, pc_out;
    logic         wr_en, flag_en, z_flag;
    logic [3:0]   flag_in;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state, computed from the requirements.
    logic [W-1:0] m_gpr [1:4];
    logic [3:0]   m_flags;
    logic [W-1:0] m_pc;

    always #2 clk = ~clk;

    regbank_flagpc i_regbank_flagpc (.*);

    function automatic logic [W-1:0] expect_of(input logic [2:0] c);
        case (c)
            3'd1, 3'd2, 3'd3, 3'd4: return m_gpr[c];
            3'd5:                   return {12'h000, m_flags};
            3'd7:                   return m_pc;
            default:                return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0:                   return "R2 zero code";
            3'd5:                   return "R4 status read";
            3'd6:                   return "R6 unused code";
            3'd7:                   return "R8 pc read";
            default:                return "R3 general reg";
        endcase
    endfunction

    // Read every code through all three ports and compare.
    task automatic sweep_reads();
        for (int s = 0; s < 8; s++) begin
            sel_a = 3'(s);
            sel_b = 3'(s + 1);
            sel_d = 3'(s + 2);
            #0.2;
            check(tag_of(sel_a), data_a, expect_of(sel_a));
            check(tag_of(sel_b), data_b, expect_of(sel_b));
            check(tag_of(sel_d), data_d, expect_of(sel_d));
        end
        check("R7 pc_out", pc_out, m_pc);
        check("R9 z_flag", {15'h0, z_flag}, {15'h0, m_flags[0]});
    endtask

    // One clock cycle with the given write and flag stimulus; updates the model.
    task automatic cyc(input logic we, input logic [2:0] ws, input logic [W-1:0] wd,
                       input logic fe, input logic [3:0] fi);
        wr_en = we; wr_sel = ws; wr_data = wd; flag_en = fe; flag_in = fi;
        @(posedge clk);
        if (we && ws >= 3'd1 && ws <= 3'd4) m_gpr[ws] = wd;
        if (fe) m_flags = fi;
        m_pc = (we && ws == 3'd7) ? wd : m_pc + 16'd1;
        @(negedge clk);
        wr_en = 1'b0; flag_en = 1'b0;
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lfsr;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        flag_en = 1'b0; flag_in = '0; sel_a = '0; sel_b = '0; sel_d = '0;
        for (int i = 1; i <= 4; i++) m_gpr[i] = '0;
        m_flags = '0; m_pc = '0;

        // R1: reset state, driving writes that must be blocked by reset.
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = 16'hFFFF; flag_en = 1'b1; flag_in = 4'hF;
        repeat (3) @(negedge clk);
        wr_en = 1'b0; flag_en = 1'b0;
        sweep_reads();
        check("R1 reset pc", pc_out, 16'h0000);
        rst_n = 1'b1;

        // R2 R3 R6 R8: write each code in turn and read everything back.
        cyc(1'b1, 3'd1, 16'h0F0F, 1'b1, 4'b1011);
        sweep_reads();
        for (int c = 0; c < 8; c++) begin
            cyc(1'b1, 3'(c), 16'hA000 + 16'(c * 16'h0111), 1'b0, 4'h0);
            sweep_reads();
        end

        // R4 R5 R9: load every status pattern, then hold it against a different input.
        for (int f = 0; f < 16; f++) begin
            cyc(1'b0, 3'd0, 16'h0, 1'b1, 4'(f));
            sweep_reads();
            cyc(1'b1, 3'd5, 16'hFFFF, 1'b0, ~4'(f));
            sweep_reads();
            cyc(1'b1, 3'd6, 16'h5A5A, 1'b0, ~4'(f));
            sweep_reads();
        end

        // R7 R8: counter wrap after an explicit load near the top.
        cyc(1'b1, 3'd7, 16'hFFFE, 1'b0, 4'h0);
        check("R8 pc load", pc_out, 16'hFFFE);
        cyc(1'b0, 3'd7, 16'h1234, 1'b0, 4'h0);
        check("R7 pc step", pc_out, 16'hFFFF);
        cyc(1'b0, 3'd0, 16'h0, 1'b0, 4'h0);
        check("R7 pc wrap", pc_out, 16'h0000);

        // R3: pseudo-random data patterns through the general registers.
        lfsr = 16'hACE1;
        for (int k = 0; k < 64; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(1'b1, 3'(1 + (k % 4)), lfsr, 1'b0, 4'h0);
            sweep_reads();
        end

        // R1: a mid-run reset clears everything again.
        rst_n = 1'b0;
        @(posedge clk);
        for (int i = 1; i <= 4; i++) m_gpr[i] = '0;
        m_flags = '0; m_pc = '0;
        @(negedge clk);
        sweep_reads();
        rst_n = 1'b1;

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule